// File: doc/BRIEF.md
# Three-Line Request Arbiter with Least-Recently-Served Rotation

This block decides which of three requesters is served in each clock cycle. It grants at most one line per cycle. Each grant is a one-cycle acknowledge pulse taken from a register. A requester that keeps its line high after being acknowledged is treated as making a new request, so it has to win arbitration again. A line that was acknowledged in one cycle is left out of arbitration in the next cycle. This keeps every acknowledge to a single-cycle pulse and lets another waiting line take its turn.

A mode input selects the priority scheme. In fixed mode the order is always line 0, then line 1, then line 2. In round-robin mode the block keeps a three-slot order register. The line just served moves to the last slot, and the other two lines keep their relative order. The result is a least-recently-served ranking, not a rotating pointer. The order register holds its contents while fixed mode is selected, and round-robin arbitration resumes from that stored order. Reset is asynchronous and active low.

Top module: `arb3_lrs_top`

## Requirements
- R1: While `rst_n` is low, `ack` is 3'b000 at once, without waiting for a clock edge. After release, the stored order is line 0 > line 1 > line 2, where slot 0 is the highest priority. Bit i of `req`/`ack` belongs to line i.
- R2: `ack` is registered. It changes only on a rising clock edge and is always one-hot or all zero.
- R3: `ack[i]` is high in a cycle only if `req[i]` was high at the rising edge that loaded it.
- R4: A line acknowledged in one cycle cannot be acknowledged in the next cycle. A line that holds its request alone is therefore acknowledged every other cycle.
- R5: If any line has its request high and was not acknowledged in the current cycle, some line is acknowledged in the next cycle.
- R6: With `rr_mode` = 0, the eligible line with the lowest index wins.
- R7: With `rr_mode` = 1, the eligible line ranked highest in the stored order wins. The winner then moves to the last slot and the other two keep their relative order. Serving line 1 from 0>1>2 gives 0>2>1, and serving line 0 from 0>1>2 gives 1>2>0.
- R8: While `rr_mode` = 0 the stored order does not change. After a return to `rr_mode` = 1, arbitration uses the order as it stood before fixed mode.
- R9: A reset asserted during operation restores the order to 0>1>2 and clears `ack`. A grant pending before the reset does not mask any line afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 1 selects least-recently-served order, 0 selects fixed order |
| req | input | 3 | Request lines, bit i for line i |
| ack | output | 3 | Registered one-cycle acknowledge, one-hot or zero |

## Verification
The assertions check on every cycle that `ack` is one-hot or zero, that an acknowledge always follows a sampled request, and that no line is acknowledged twice in a row. They also check that a pending eligible request always produces a grant, that the stored order stays a permutation of the three lines, and that fixed mode leaves the order untouched. Which line should win, and how the order moves after each round-robin grant, can only be shown by the bench. It runs a cycle-accurate reference model over every pair of request patterns in both modes and over long pseudo-random runs with mode changes and a reset in mid-run.

// File: rtl/arb3_pkg.sv
package arb3_pkg;
  localparam int LINES = 3;
  localparam int IDX_W = $clog2(LINES);

  typedef logic [IDX_W-1:0]  line_idx_t;
  typedef line_idx_t [LINES-1:0] order_t;   // element 0 = highest priority
  typedef logic [LINES-1:0]  line_vec_t;

  // identity order: line k in slot k
  function automatic order_t base_order();
    order_t o;
    for (int k = 0; k < LINES; k++) o[k] = line_idx_t'(k);
    return o;
  endfunction

  // one-hot grant of the first eligible line walking the order
  function automatic line_vec_t pick_first(order_t ord, line_vec_t elig);
    line_vec_t g;
    logic      found;
    g     = '0;
    found = 1'b0;
    for (int s = 0; s < LINES; s++) begin
      if (!found && elig[ord[s]]) begin
        g[ord[s]] = 1'b1;
        found     = 1'b1;
      end
    end
    return g;
  endfunction

  // remove 'who' from the order, close the gap, append it last
  function automatic order_t send_to_back(order_t ord, line_idx_t who);
    order_t n;
    int     j;
    n = ord;
    j = 0;
    for (int k = 0; k < LINES; k++) begin
      if (ord[k] != who) begin
        n[j] = ord[k];
        j    = j + 1;
      end
    end
    n[LINES-1] = who;
    return n;
  endfunction

  function automatic line_idx_t vec_to_idx(line_vec_t v);
    line_idx_t r;
    r = '0;
    for (int k = 0; k < LINES; k++) if (v[k]) r = line_idx_t'(k);
    return r;
  endfunction
endpackage

// File: rtl/arb3_order_reg.sv
module arb3_order_reg
  import arb3_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd_en,
  input  line_idx_t served_idx,
  output order_t    order_q
);
  order_t order_d;

  always_comb begin
    order_d = order_q;
    if (upd_en) order_d = send_to_back(order_q, served_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) order_q <= base_order();
    else        order_q <= order_d;
  end

  // occupancy of lines across slots: must always be a full permutation
  line_vec_t slot_seen;
  always_comb begin
    slot_seen = '0;
    for (int s = 0; s < LINES; s++) slot_seen[order_q[s]] = 1'b1;
  end

  a_r7_order_is_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    slot_seen == {LINES{1'b1}});

  a_r8_order_holds_without_update: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(order_q));

  a_r7_served_goes_last: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> order_q[LINES-1] == $past(served_idx));
endmodule

// File: rtl/arb3_select.sv
module arb3_select
  import arb3_pkg::*;
(
  input  logic      rr_mode,
  input  line_vec_t req,
  input  line_vec_t ack_q,
  input  order_t    order_q,
  output line_vec_t eligible,
  output line_vec_t grant
);
  order_t active_order;

  // a line served last cycle sits out this cycle
  for (genvar i = 0; i < LINES; i++) begin : g_mask
    assign eligible[i] = req[i] & ~ack_q[i];
  end

  assign active_order = rr_mode ? order_q : base_order();
  assign grant        = pick_first(active_order, eligible);

  always_comb begin
    a_r2_grant_onehot0: assert ($onehot0(grant) || $isunknown(grant));
  end
endmodule

// File: rtl/arb3_ack_reg.sv
module arb3_ack_reg
  import arb3_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t grant,
  output line_vec_t ack_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= '0;
    else        ack_q <= grant;
  end

  a_r2_ack_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_q));

  for (genvar i = 0; i < LINES; i++) begin : g_pulse
    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q[i] |=> !ack_q[i]);
  end
endmodule

// File: rtl/arb3_lrs_top.sv
module arb3_lrs_top
  import arb3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rr_mode,
  input  logic [LINES-1:0] req,
  output logic [LINES-1:0] ack
);
  order_t    order_q;
  line_vec_t ack_q;
  line_vec_t eligible;
  line_vec_t grant;
  logic      any_grant;
  logic      order_upd;
  line_idx_t served_idx;

  assign any_grant  = |grant;
  assign order_upd  = rr_mode & any_grant;
  assign served_idx = vec_to_idx(grant);
  assign ack        = ack_q;

  arb3_select u_select (
    .rr_mode  (rr_mode),
    .req      (req),
    .ack_q    (ack_q),
    .order_q  (order_q),
    .eligible (eligible),
    .grant    (grant)
  );

  arb3_order_reg u_order (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (order_upd),
    .served_idx (served_idx),
    .order_q    (order_q)
  );

  arb3_ack_reg u_ack (
    .clk   (clk),
    .rst_n (rst_n),
    .grant (grant),
    .ack_q (ack_q)
  );

  a_r5_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req & ~ack)) |=> (|ack));

  for (genvar i = 0; i < LINES; i++) begin : g_cause
    a_r3_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      ack[i] |-> $past(req[i]));
  end

  a_r6_fixed_line0_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!rr_mode && req[0] && !ack[0]) |=> ack[0]);
endmodule

// File: tb/sim_arb3_lrs_top.sv
`timescale 1ns/1ps
module sim_arb3_lrs_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rr_mode = 1'b0;
  logic [2:0] req = 3'b000;
  logic [2:0] ack;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int         m_ord [3];
  logic [2:0] m_ack;
  logic [2:0] prev_req;
  logic [2:0] prev_ack;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;   // 125 MHz

  arb3_lrs_top u0 (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .req(req), .ack(ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: ack actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++) m_ord[k] = k;
    m_ack = 3'b000;
  endtask

  // one rising edge of the reference: winner, then order shuffle
  task automatic model_step(input logic mode, input logic [2:0] r);
    logic [2:0] elig;
    int win;
    int tmp [3];
    int j;
    elig = r & ~m_ack;
    win  = -1;
    for (int p = 0; p < 3; p++) begin
      int line;
      line = mode ? m_ord[p] : p;
      if (win < 0 && elig[line]) win = line;
    end
    m_ack = (win >= 0) ? 3'(1 << win) : 3'b000;
    if (mode && win >= 0) begin
      j = 0;
      for (int p = 0; p < 3; p++) if (m_ord[p] != win) begin tmp[j] = m_ord[p]; j++; end
      tmp[2] = win;
      for (int p = 0; p < 3; p++) m_ord[p] = tmp[p];
    end
  endtask

  // called at a falling edge; drives inputs, steps one cycle, checks
  task automatic cycle(input logic mode, input logic [2:0] r);
    string tag;
    tag = mode ? "R7" : "R6";
    rr_mode  = mode;
    req      = r;
    prev_req = r;
    prev_ack = ack;
    model_step(mode, r);
    @(posedge clk);
    @(negedge clk);
    chk(ack === m_ack, tag, ack, m_ack);
    chk($onehot0(ack), "R2", ack, m_ack);
    chk((ack & ~prev_req) == 3'b000, "R3", ack, ack & prev_req);
    chk((ack & prev_ack) == 3'b000, "R4", ack, ack & ~prev_ack);
    if (|(prev_req & ~prev_ack)) chk(|ack, "R5", ack, m_ack);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    model_reset();
    // R1: asynchronous clear, observed before any clock edge
    #2;
    chk(ack === 3'b000, "R1", ack, 3'b000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ack === 3'b000, "R1", ack, 3'b000);
    rst_n = 1'b1;

    // R1: reset order 0>1>2 seen through round-robin grants
    cycle(1'b1, 3'b111);  // line 0 wins, order 1>2>0
    chk(ack === 3'b001, "R1", ack, 3'b001);
    cycle(1'b1, 3'b111);  // line 1 wins
    chk(ack === 3'b010, "R7", ack, 3'b010);

    // R4: lone held request pulses every other cycle
    cycle(1'b0, 3'b000);
    cycle(1'b0, 3'b100);
    chk(ack === 3'b100, "R4", ack, 3'b100);
    cycle(1'b0, 3'b100);
    chk(ack === 3'b000, "R4", ack, 3'b000);
    cycle(1'b0, 3'b100);
    chk(ack === 3'b100, "R4", ack, 3'b100);

    // R9: reset in mid-run, asserted away from the edge
    #1 rst_n = 1'b0;
    #1 chk(ack === 3'b000, "R9", ack, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    // from 0>1>2: serve line 1 -> 0>2>1; then 0, then 2
    cycle(1'b1, 3'b010);
    chk(ack === 3'b010, "R9", ack, 3'b010);
    cycle(1'b1, 3'b111);
    chk(ack === 3'b001, "R7", ack, 3'b001);
    cycle(1'b1, 3'b111);
    chk(ack === 3'b100, "R7", ack, 3'b100);

    // R8: fixed mode leaves the order; round-robin resumes from it
    cycle(1'b0, 3'b000);
    for (int n = 0; n < 6; n++) cycle(1'b0, 3'b111);
    cycle(1'b0, 3'b000);
    cycle(1'b1, 3'b111);   // order held at 1>0>2
    chk(ack === 3'b010, "R8", ack, 3'b010);

    // exhaustive pattern pairs in both modes
    for (int md = 0; md < 2; md++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          cycle(md[0], 3'(a));
          cycle(md[0], 3'(b));
          cycle(md[0], 3'(b));
        end

    // pseudo-random run with mode changes
    for (int n = 0; n < 3000; n++) begin
      step_lfsr();
      cycle((n % 97) < 70 ? 1'b1 : lfsr[5], lfsr[2:0]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule